// File: doc/BRIEF.md
# Per-Lane Variable Vector Shifter

This block shifts every element of a 256-bit vector operand by its own amount. The amount for each element comes from the element in the same position of a second 256-bit operand. A caller picks the operation (logical left, logical right or arithmetic right), the element size (32-bit or 64-bit) and the active vector length (128 or 256 bits). The result and a valid flag come out of a register one clock after the request.

Each lane reads the whole element of the second operand as its count; the count is never cut down to its low bits. A logical shift by the element width or more gives zero. An arithmetic shift by the element width or more fills the lane with its sign bit. A 128-bit request clears the upper half of the result. The reserved operation code still returns a valid flag, with an all-zero result, so the output timing is the same for every request.

Top module: `vshift_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and every bit of `result` become 0 at that edge.
- R2: `out_valid` equals `in_valid` of the previous clock edge. `result` is loaded only on an edge where `in_valid` is high and otherwise keeps its value.
- R3: The operation code `op` selects the shift: 0 is logical left, 1 is logical right (zero fill), 2 is arithmetic right (sign fill). Each lane uses the count taken from the element of `src_b` at the same bit position.
- R4: A lane's count is the full element of `src_b` (32 or 64 bits). Set bits above the low 5 (or 6) bits take part in the count. For example, a dword count of 0x100 is treated as 256, not 0.
- R5: A logical shift with a count greater than or equal to the element width gives an all-zero lane.
- R6: An arithmetic right shift with a count greater than or equal to the element width fills the lane with its sign bit. For example, 0x80000000 shifted by 0x20 gives 0xFFFFFFFF.
- R7: `esize`=0 selects eight 32-bit lanes at bits [32i+31:32i]. `esize`=1 selects four 64-bit lanes at bits [64i+63:64i].
- R8: `vlen`=0 processes the low 128 bits and forces `result[255:128]` to 0. `vlen`=1 processes all 256 bits.
- R9: `op`=3 is reserved. It gives an all-zero `result` with `out_valid` asserted on the usual cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| src_a | input | 256 | Values to shift |
| src_b | input | 256 | Per-lane shift counts |
| op | input | 2 | 0 left, 1 logical right, 2 arithmetic right, 3 reserved |
| esize | input | 1 | 0: 32-bit lanes, 1: 64-bit lanes |
| vlen | input | 1 | 0: 128-bit, 1: 256-bit |
| out_valid | output | 1 | Result valid |
| result | output | 256 | Registered shift result |

## Verification
Every result is due exactly one rising edge after the edge that samples its request. The driver applies each request at a falling edge and pushes the expected vector into a queue. The monitor samples at the next falling edge, pops one entry whenever `out_valid` is high, and counts a missing or extra result as a failure. Idle cycles are checked at the same point, one edge after `in_valid` drops, to confirm the flag falls and the result holds.

// File: rtl/vshift_pkg.sv
package vshift_pkg;
    localparam int VS_DATA_W = 256;
    localparam int VS_HALF_W = VS_DATA_W / 2;

    typedef enum logic [1:0] {
        OP_SLL  = 2'd0,
        OP_SRL  = 2'd1,
        OP_SRA  = 2'd2,
        OP_RSVD = 2'd3
    } shift_op_t;

    typedef struct packed {
        logic                 vld;
        logic [VS_DATA_W-1:0] res;
    } vs_state_t;
endpackage

// File: rtl/vshift_lane.sv
module vshift_lane
    import vshift_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] cnt_i,
    input  logic [1:0]   op_i,
    output logic [W-1:0] res_o
);
    localparam int SW = $clog2(W);

    logic          big;
    logic [SW-1:0] amt;
    logic [W-1:0]  sll_v;
    logic [W-1:0]  srl_v;
    logic [W-1:0]  sra_v;

    assign big = |cnt_i[W-1:SW];
    assign amt = cnt_i[SW-1:0];

    always_comb begin
        sll_v = big ? '0 : (val_i << amt);
        srl_v = big ? '0 : (val_i >> amt);
        sra_v = big ? {W{val_i[W-1]}} : W'($signed(val_i) >>> amt);
        unique case (op_i)
            OP_SLL:  res_o = sll_v;
            OP_SRL:  res_o = srl_v;
            OP_SRA:  res_o = sra_v;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/vshift_select.sv
module vshift_select
    import vshift_pkg::*;
(
    input  logic [VS_DATA_W-1:0] r32_i,
    input  logic [VS_DATA_W-1:0] r64_i,
    input  logic                 esize_i,
    input  logic [1:0]           op_i,
    input  logic                 vlen_i,
    output logic [VS_DATA_W-1:0] res_o
);
    logic [VS_DATA_W-1:0] picked;

    always_comb begin
        picked = esize_i ? r64_i : r32_i;
        if (op_i == OP_RSVD) begin
            picked = '0;
        end
        res_o = picked;
        if (!vlen_i) begin
            res_o[VS_DATA_W-1:VS_HALF_W] = '0;
        end
    end
endmodule

// File: rtl/vshift_unit.sv
module vshift_unit
    import vshift_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [VS_DATA_W-1:0] src_a,
    input  logic [VS_DATA_W-1:0] src_b,
    input  logic [1:0]           op,
    input  logic                 esize,
    input  logic                 vlen,
    output logic                 out_valid,
    output logic [VS_DATA_W-1:0] result
);
    localparam int N32 = VS_DATA_W / 32;
    localparam int N64 = VS_DATA_W / 64;

    logic [VS_DATA_W-1:0] r32;
    logic [VS_DATA_W-1:0] r64;
    logic [VS_DATA_W-1:0] sel;
    vs_state_t            state_d;
    vs_state_t            state_q;

    for (genvar i = 0; i < N32; i++) begin : g_d
        vshift_lane #(.W(32)) u_lane (
            .val_i (src_a[32*i +: 32]),
            .cnt_i (src_b[32*i +: 32]),
            .op_i  (op),
            .res_o (r32[32*i +: 32])
        );
    end

    for (genvar j = 0; j < N64; j++) begin : g_q
        vshift_lane #(.W(64)) u_lane (
            .val_i (src_a[64*j +: 64]),
            .cnt_i (src_b[64*j +: 64]),
            .op_i  (op),
            .res_o (r64[64*j +: 64])
        );
    end

    vshift_select u_sel (
        .r32_i   (r32),
        .r64_i   (r64),
        .esize_i (esize),
        .op_i    (op),
        .vlen_i  (vlen),
        .res_o   (sel)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.res = sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.res;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0)); // R1
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result))); // R2
    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !vlen) |=> (result[VS_DATA_W-1:VS_HALF_W] == '0)); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_RSVD) |=> (out_valid && result == '0)); // R9
    AST_SRA_FILL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_SRA && !esize && src_b[31:0] >= 32'd32)
        |=> (result[31:0] == {32{$past(src_a[31])}})); // R6
    AST_LOGIC_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_SLL && !esize && src_b[31:0] >= 32'd32)
        |=> (result[31:0] == '0)); // R5
endmodule

// File: tb/sim_vshift_unit.sv
module sim_vshift_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [255:0] src_a, src_b;
    logic [1:0]   op;
    logic         esize, vlen;
    logic         out_valid;
    logic [255:0] result;

    int errors = 0;
    int checks = 0;
    logic [255:0] exp_q[$];
    string        tag_q[$];

    vshift_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .op(op), .esize(esize), .vlen(vlen), .out_valid(out_valid), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [255:0] model(logic [255:0] a, logic [255:0] b,
                                           logic [1:0] o, logic es, logic vl);
        logic [255:0] r = '0;
        if (o == 2'd3) return '0;
        if (!es) begin
            for (int i = 0; i < 8; i++) begin
                logic [31:0] x = a[32*i +: 32];
                logic [31:0] c = b[32*i +: 32];
                logic [31:0] y;
                if (c >= 32) y = (o == 2'd2 && x[31]) ? 32'hFFFF_FFFF : 32'h0;
                else if (o == 2'd0) y = x << c;
                else if (o == 2'd1) y = x >> c;
                else begin
                    y = x >> c;
                    for (int k = 0; k < 32; k++) if (x[31] && k >= 32 - int'(c)) y[k] = 1'b1;
                end
                r[32*i +: 32] = y;
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                logic [63:0] x = a[64*i +: 64];
                logic [63:0] c = b[64*i +: 64];
                logic [63:0] y;
                if (c >= 64) y = (o == 2'd2 && x[63]) ? '1 : '0;
                else if (o == 2'd0) y = x << c;
                else if (o == 2'd1) y = x >> c;
                else begin
                    y = x >> c;
                    for (int k = 0; k < 64; k++) if (x[63] && k >= 64 - int'(c)) y[k] = 1'b1;
                end
                r[64*i +: 64] = y;
            end
        end
        if (!vl) r[255:128] = '0;
        return r;
    endfunction

    task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(string tag, logic [255:0] a, logic [255:0] b,
                         logic [1:0] o, logic es, logic vl);
        @(negedge clk);
        in_valid = 1'b1; src_a = a; src_b = b; op = o; esize = es; vlen = vl;
        exp_q.push_back(model(a, b, o, es, vl));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        src_a = {8{32'hDEAD_BEEF}};
        src_b = '0;
    endtask

    // Monitor: one result due one edge after each accepted request (R2)
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected valid", 256'd1, 256'd0);
                end else begin
                    check(tag_q.pop_front(), result, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [255:0] held;
        rst = 1'b1; in_valid = 1'b0; src_a = '1; src_b = '0; op = 2'd0; esize = 1'b0; vlen = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", {255'd0, out_valid}, 256'd0);
        check("R1 reset result", result, 256'd0);
        rst = 1'b0;

        // R6: the dword lane-3 sign-fill example, 128-bit length
        drive("R6 R8 sra dword 0x20", {128'd0, 32'h8000_0000, 96'd0},
              {128'd0, 32'h0000_0020, 96'd0}, 2'd2, 1'b0, 1'b0);
        // R3 R7: per-lane distinct dword counts 0,1,31,32,33,0xFFFFFFFF,0x100,5
        drive("R3 R7 sll dword", {8{32'h8765_4321}},
              {32'd5, 32'h100, 32'hFFFF_FFFF, 32'd33, 32'd32, 32'd31, 32'd1, 32'd0},
              2'd0, 1'b0, 1'b1);
        drive("R3 R5 srl dword", {8{32'hF00F_1234}},
              {32'd5, 32'h100, 32'hFFFF_FFFF, 32'd33, 32'd32, 32'd31, 32'd1, 32'd0},
              2'd1, 1'b0, 1'b1);
        drive("R6 sra dword", {4{32'h9ABC_DEF0, 32'h1234_5678}},
              {32'd5, 32'h100, 32'hFFFF_FFFF, 32'd33, 32'd32, 32'd31, 32'd1, 32'd0},
              2'd2, 1'b0, 1'b1);
        // R4: count 0x100 and 0x8000_0001 must not act as 0 or 1
        drive("R4 full dword count", {8{32'hFFFF_FFFF}},
              {4{32'h8000_0001, 32'h0000_0100}}, 2'd1, 1'b0, 1'b1);
        // R7 qword lanes, counts 0,1,63,64 then 65, high bits, 2
        drive("R7 sll qword", {4{64'hC123_4567_89AB_CDEF}},
              {64'd64, 64'd63, 64'd1, 64'd0}, 2'd0, 1'b1, 1'b1);
        drive("R5 srl qword", {4{64'hC123_4567_89AB_CDEF}},
              {64'd2, 64'h1_0000_0000, 64'd65, 64'd63}, 2'd1, 1'b1, 1'b1);
        drive("R6 sra qword", {64'h8000_0000_0000_0000, 64'hF000_0000_0000_0001,
              64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0010},
              {64'd65, 64'd63, 64'd64, 64'd4}, 2'd2, 1'b1, 1'b1);
        drive("R4 qword high count", {4{64'hFFFF_FFFF_FFFF_FFFF}},
              {4{64'h8000_0000_0000_0001}}, 2'd0, 1'b1, 1'b1);
        // R8: 128-bit length clears the top half for qword and dword
        drive("R8 vlen128 qword", {4{64'h0123_4567_89AB_CDEF}},
              {4{64'd4}}, 2'd0, 1'b1, 1'b0);
        drive("R8 vlen128 dword", {8{32'h8000_00FF}},
              {8{32'd3}}, 2'd2, 1'b0, 1'b0);
        // R9: reserved op
        drive("R9 reserved op", {8{32'hFFFF_FFFF}}, '0, 2'd3, 1'b0, 1'b1);
        drive("R3 after reserved", {8{32'h0000_0001}},
              {32'd7, 32'd6, 32'd5, 32'd4, 32'd3, 32'd2, 32'd1, 32'd0}, 2'd0, 1'b0, 1'b1);

        // R2: idle cycle holds the last result and drops the flag
        idle();
        held = model({8{32'h0000_0001}},
                     {32'd7, 32'd6, 32'd5, 32'd4, 32'd3, 32'd2, 32'd1, 32'd0}, 2'd0, 1'b0, 1'b1);
        @(negedge clk);
        check("R2 idle valid low", {255'd0, out_valid}, 256'd0);
        check("R2 idle hold", result, held);
        @(negedge clk);
        check("R2 second idle hold", result, held);

        // Patterned sweep over every op/size/length
        for (int k = 0; k < 16; k++) begin
            logic [255:0] a, b;
            for (int w = 0; w < 8; w++) begin
                a[32*w +: 32] = 32'h9E37_79B9 * (k * 8 + w + 1);
                b[32*w +: 32] = (k[0]) ? 32'((k * 3 + w * 7) % 70) : 32'(w * 9 + k);
            end
            drive("R3 R7 sweep", a, b, 2'(k % 3), k[1], k[2]);
        end
        idle();
        repeat (3) @(negedge clk);
        check("R2 queue drained", 256'(exp_q.size()), 256'd0);

        // R1: reset mid-stream clears state
        drive("R3 pre-reset", {8{32'h1}}, '0, 2'd0, 1'b0, 1'b1);
        idle();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset after data", result, 256'd0);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule